// File: doc/BRIEF.md
# Keyed Multi-Lane Serial Memory Port

This block is a half-duplex serial slave that lets a host read and write an internal word memory over a bus of several parallel data lanes. The host drives a serial clock and an active-low select. Every time the select goes low, the first thing the host must shift in is an access key. A matching key opens a short command header: a command byte that picks read or write, then a start address. After the header, data words stream in or out. An internal address counter steps by one after every word, so the memory side needs no help from any other controller.

A key that does not match turns the same address counter into a lockout timer. For exactly 2^ADDR_W serial clocks the port ignores the lanes, keeps its lane drivers off and raises a denied interrupt. After that it waits for a fresh key. A second interrupt line gives a one-clock pulse after each word that completes. Every state change happens on the rising edge of the serial clock. The lanes are modelled as separate input, output and output-enable vectors. The memory is external to the block and has an asynchronous read port and a write strobe.

Top module: `keyed_spi_mem_port`

## Requirements
- R1: While reset is asserted and after it is released, the lane output enables, the memory write strobe and both interrupt lines are low, and the port waits for a key.
- R2: The key is shifted in most-significant bits first, LANES bits per rising clock edge, over KEY_W/LANES edges. When it equals KEY_VALUE, the command phase opens.
- R3: After a good key come two more fields, both shifted most-significant bits first. The first is a command byte, where bit 0 set means read and bit 0 clear means write. The second is an ADDR_W-bit start address.
- R4: On a write, each complete WORD_W-bit word is written at the current counter address, and the counter then increments. irq_done is high for exactly the one clock that follows each written word.
- R5: On a read, one idle turnaround clock follows the address. After it, the port drives words most-significant bits first from consecutive addresses, starting at the start address. All lane output enables are high only during read data clocks.
- R6: The address counter wraps modulo 2^ADDR_W, so the word after address all-ones goes to address zero.
- R7: Raising the select outside a lockout returns the port to key wait at the next edge. A partly shifted word is discarded, and the next selection must start with the key again.
- R8: A key that does not match starts a lockout. irq_denied is high for exactly 2^ADDR_W clocks, whatever the select does. During that time the lanes are never driven and no write occurs, even if the correct key is sent.
- R9: When a lockout ends, the port returns to key wait, and a correct key opens access again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low port select |
| lane_in | input | LANES | Lane values driven by the host |
| lane_out | output | LANES | Lane values driven by the port during read data |
| lane_oe | output | LANES | Per-lane output enable, all high only in read data clocks |
| irq_denied | output | 1 | High while a lockout runs |
| irq_done | output | 1 | One-clock pulse after each completed word |
| mem_addr | output | ADDR_W | Memory address, taken from the address counter |
| mem_wdata | output | WORD_W | Word to write |
| mem_we | output | 1 | Write strobe, valid at the rising edge |
| mem_rdata | input | WORD_W | Asynchronous read data at mem_addr |

## Verification
The bench targets the wrap from the all-ones address to zero. A counter that saturated, or that went wider than the address, would show up as a wrong address on the second write. It also drops the select partway through a word and partway through the key. A design that flushed the partial word, or that kept the half key, would show an extra write or would refuse the next key. The lockout is measured clock by clock, and the correct key is sent while it runs. A timer that is off by one, that restarts when the select changes, or that accepts a key early would show up as a wrong denied count or as a write that should not occur. Reads check the idle turnaround clock and the output enables on every beat.

// File: rtl/kspi_pkg.sv
package kspi_pkg;

  typedef enum logic [2:0] {
    ST_KEY   = 3'd0,
    ST_CMD   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_TURN  = 3'd3,
    ST_WDATA = 3'd4,
    ST_RDATA = 3'd5,
    ST_LOCK  = 3'd6
  } kspi_state_e;

  localparam int CMD_W = 8;

  // number of clock beats needed to move a field over the lanes
  function automatic int beats_of(input int bits, input int lanes);
    return (bits + lanes - 1) / lanes;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // address step with wrap at the counter width
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input int w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v + 32'd1) & mask;
  endfunction

endpackage

// File: rtl/kspi_deser.sv
module kspi_deser #(
  parameter int LANES = 4,
  parameter int SH_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [LANES-1:0] lane_in,
  output logic [SH_W-1:0]  word_now
);
  logic [SH_W-1:0] sh_q;

  // value including the beat on the lanes right now
  assign word_now = {sh_q[SH_W-LANES-1:0], lane_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= word_now;
  end
endmodule

// File: rtl/kspi_ser.sv
module kspi_ser #(
  parameter int LANES  = 4,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              shift,
  output logic [LANES-1:0]  lanes
);
  logic [WORD_W-1:0] out_q;

  assign lanes = out_q[WORD_W-1 -: LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= '0;
    else if (load)  out_q <= load_val;
    else if (shift) out_q <= out_q << LANES;
  end
endmodule

// File: rtl/kspi_cnt.sv
module kspi_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  import kspi_pkg::*;

  logic [W-1:0] cnt_q;
  assign cnt    = cnt_q;
  assign at_max = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (inc)   cnt_q <= W'(wrap_inc(32'(cnt_q), W));
  end

  // counter steps by one and wraps (R6, lockout timing R8)
  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !clear) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/kspi_ctrl.sv
module kspi_ctrl #(
  parameter int              LANES     = 4,
  parameter int              KEY_W     = 16,
  parameter int              ADDR_W    = 16,
  parameter int              WORD_W    = 8,
  parameter int              SH_W      = 16,
  parameter int              BC_W      = 3,
  parameter logic [KEY_W-1:0] KEY_VALUE = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic [SH_W-1:0]        word_now,
  input  logic                   at_max,
  output kspi_pkg::kspi_state_e  state,
  output logic                   key_bad,
  output logic                   addr_load,
  output logic                   wr_word,
  output logic                   rd_fetch,
  output logic                   rd_done,
  output logic                   locked
);
  import kspi_pkg::*;

  localparam int KEY_B  = beats_of(KEY_W, LANES);
  localparam int CMD_B  = beats_of(CMD_W, LANES);
  localparam int ADDR_B = beats_of(ADDR_W, LANES);
  localparam int WORD_B = beats_of(WORD_W, LANES);

  kspi_state_e     state_q;
  logic [BC_W-1:0] beat_q;
  logic [BC_W-1:0] ph_last;
  logic            rd_q;
  logic            active, is_last, key_hit;

  always_comb begin
    case (state_q)
      ST_KEY:  ph_last = BC_W'(KEY_B - 1);
      ST_CMD:  ph_last = BC_W'(CMD_B - 1);
      ST_ADDR: ph_last = BC_W'(ADDR_B - 1);
      default: ph_last = BC_W'(WORD_B - 1);
    endcase
  end

  assign active    = !cs_n && (state_q != ST_LOCK);
  assign is_last   = (beat_q == ph_last);
  assign key_hit   = (word_now[KEY_W-1:0] == KEY_VALUE);
  assign key_bad   = active && (state_q == ST_KEY) && is_last && !key_hit;
  assign addr_load = active && (state_q == ST_ADDR) && is_last;
  assign wr_word   = active && (state_q == ST_WDATA) && is_last;
  assign rd_done   = active && (state_q == ST_RDATA) && is_last;
  assign rd_fetch  = active && ((state_q == ST_TURN) || rd_done);
  assign locked    = (state_q == ST_LOCK);
  assign state     = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_KEY;
      beat_q  <= '0;
      rd_q    <= 1'b0;
    end else if (state_q == ST_LOCK) begin
      beat_q <= '0;
      if (at_max) state_q <= ST_KEY;
    end else if (cs_n) begin
      state_q <= ST_KEY;
      beat_q  <= '0;
    end else begin
      beat_q <= is_last ? '0 : beat_q + 1'b1;
      case (state_q)
        ST_KEY:   if (is_last) state_q <= key_hit ? ST_CMD : ST_LOCK;
        ST_CMD:   if (is_last) begin
                    rd_q    <= word_now[0];
                    state_q <= ST_ADDR;
                  end
        ST_ADDR:  if (is_last) state_q <= rd_q ? ST_TURN : ST_WDATA;
        ST_TURN:  begin
                    state_q <= ST_RDATA;
                    beat_q  <= '0;
                  end
        default:  state_q <= state_q;
      endcase
    end
  end

  // lockout ignores the select until the timer reaches its top (R8)
  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && !at_max) |=> (state_q == ST_LOCK));

  assert_bad_key_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_bad |=> (state_q == ST_LOCK));

  // deselect outside lockout goes back to key wait (R7)
  assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && state_q != ST_LOCK) |=> (state_q == ST_KEY));

  // exactly one turnaround clock before read data (R5)
  assert_turn_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TURN && !cs_n) |=> (state_q == ST_RDATA));

  // lockout end returns to key wait (R9)
  assert_lock_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && at_max) |=> (state_q == ST_KEY));
endmodule

// File: rtl/keyed_spi_mem_port.sv
module keyed_spi_mem_port #(
  parameter int               LANES     = 4,
  parameter int               KEY_W     = 16,
  parameter int               ADDR_W    = 16,
  parameter int               WORD_W    = 8,
  parameter logic [KEY_W-1:0] KEY_VALUE = 16'hA5C3
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [LANES-1:0]  lane_in,
  output logic [LANES-1:0]  lane_out,
  output logic [LANES-1:0]  lane_oe,
  output logic              irq_denied,
  output logic              irq_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata
);
  import kspi_pkg::*;

  localparam int SH_W = max2(max2(KEY_W, ADDR_W), max2(WORD_W, CMD_W));
  localparam int MAXB = max2(max2(beats_of(KEY_W, LANES), beats_of(ADDR_W, LANES)),
                             max2(beats_of(WORD_W, LANES), beats_of(CMD_W, LANES)));
  localparam int BC_W = $clog2(MAXB) + 1;

  kspi_state_e     state;
  logic [SH_W-1:0] word_now;
  logic [ADDR_W-1:0] cnt;
  logic            at_max, key_bad, addr_load, wr_word, rd_fetch, rd_done, locked;
  logic            done_q;

  kspi_deser #(.LANES(LANES), .SH_W(SH_W)) u_deser (
    .clk(sclk), .rst_n(rst_n), .shift_en(!cs_n), .lane_in(lane_in), .word_now(word_now)
  );

  kspi_ctrl #(
    .LANES(LANES), .KEY_W(KEY_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .SH_W(SH_W), .BC_W(BC_W), .KEY_VALUE(KEY_VALUE)
  ) u_ctrl (
    .clk(sclk), .rst_n(rst_n), .cs_n(cs_n), .word_now(word_now), .at_max(at_max),
    .state(state), .key_bad(key_bad), .addr_load(addr_load), .wr_word(wr_word),
    .rd_fetch(rd_fetch), .rd_done(rd_done), .locked(locked)
  );

  kspi_cnt #(.W(ADDR_W)) u_cnt (
    .clk(sclk), .rst_n(rst_n), .clear(key_bad), .load(addr_load),
    .load_val(word_now[ADDR_W-1:0]), .inc(locked || wr_word || rd_fetch),
    .cnt(cnt), .at_max(at_max)
  );

  kspi_ser #(.LANES(LANES), .WORD_W(WORD_W)) u_ser (
    .clk(sclk), .rst_n(rst_n), .load(rd_fetch), .load_val(mem_rdata),
    .shift(!cs_n && state == ST_RDATA), .lanes(lane_out)
  );

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= wr_word || rd_done;
  end

  assign lane_oe    = {LANES{!cs_n && state == ST_RDATA}};
  assign irq_denied = locked;
  assign irq_done   = done_q;
  assign mem_addr   = cnt;
  assign mem_wdata  = word_now[WORD_W-1:0];
  assign mem_we     = wr_word;

  // lanes never driven while locked or writing (R5, R8)
  assert_oe_quiet_R8: assert property (@(posedge sclk) disable iff (!rst_n)
    (|lane_oe) |-> (!irq_denied && !mem_we));

  // completion pulse follows each written word (R4)
  assert_done_pulse_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    mem_we |=> irq_done);

  // no write during lockout (R8)
  assert_no_write_locked_R8: assert property (@(posedge sclk) disable iff (!rst_n)
    irq_denied |-> !mem_we);
endmodule

// File: tb/tb_keyed_spi_mem_port.sv
`timescale 1ns/1ps
module tb_keyed_spi_mem_port;
  localparam int   LANES = 4;
  localparam int   AW    = 16;
  localparam logic [15:0] KEY = 16'hA5C3;

  logic             sclk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cs_n = 1'b1;
  logic [LANES-1:0] lane_in = '0;
  logic [LANES-1:0] lane_out, lane_oe;
  logic             irq_denied, irq_done, mem_we;
  logic [AW-1:0]    mem_addr;
  logic [7:0]       mem_wdata, mem_rdata;

  logic [7:0] mem [256];
  logic [23:0] wq [$];
  int errors = 0, checks = 0;
  int done_cnt = 0, denied_cnt = 0, oe_locked = 0;
  bit finished = 0;

  always #2.5 sclk = ~sclk;

  keyed_spi_mem_port dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .lane_in(lane_in),
    .lane_out(lane_out), .lane_oe(lane_oe), .irq_denied(irq_denied),
    .irq_done(irq_done), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write monitor: pops the expected address/data pair per strobe
  always @(posedge sclk) begin
    if (rst_n && mem_we) begin
      if (wq.size() == 0) check(1'b0, "R7/R8 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [23:0] e;
        e = wq.pop_front();
        check({mem_addr, mem_wdata} == e, "R4/R6 write addr+data", {mem_addr, mem_wdata}, e);
      end
      mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  always @(negedge sclk) begin
    if (irq_done)   done_cnt++;
    if (irq_denied) denied_cnt++;
    if (irq_denied && lane_oe != 0) oe_locked++;
  end

  task automatic send(input logic [31:0] v, input int bits);
    for (int b = bits / LANES - 1; b >= 0; b--) begin
      @(negedge sclk);
      cs_n = 1'b0;
      lane_in = v[b*LANES +: LANES];
    end
  endtask

  task automatic deselect();
    @(negedge sclk); cs_n = 1'b1; lane_in = '0;
    @(negedge sclk);
  endtask

  task automatic wr_burst(input logic [15:0] a, input logic [7:0] d[], input int n);
    logic [15:0] ad;
    int d0;
    d0 = done_cnt;
    ad = a;
    send(KEY, 16); send(8'h00, 8); send(a, 16);
    for (int i = 0; i < n; i++) begin
      wq.push_back({ad, d[i]});
      send(d[i], 8);
      ad = ad + 16'd1;
    end
    deselect();
    check(wq.size() == 0, "R4 all words written", wq.size(), 0);
    check(done_cnt - d0 == n, "R4 done pulses", done_cnt - d0, n);
  endtask

  task automatic rd_burst(input logic [15:0] a, input int n);
    logic [7:0] got, exp;
    int d0, oe_bad;
    d0 = done_cnt;
    oe_bad = 0;
    send(KEY, 16); send(8'h01, 8); send(a, 16);
    @(negedge sclk); lane_in = '0;
    check(lane_oe == 0, "R5 turnaround not driven", lane_oe, 0);
    for (int i = 0; i < n; i++) begin
      exp = mem[8'(a + 16'(i))];
      got = '0;
      for (int b = 0; b < 8 / LANES; b++) begin
        @(negedge sclk);
        if (lane_oe != {LANES{1'b1}}) oe_bad++;
        got = {got[7-LANES:0], lane_out};
      end
      check(got == exp, "R5 read word", got, exp);
    end
    check(oe_bad == 0, "R5 oe during read data", oe_bad, 0);
    deselect();
    check(lane_oe == 0, "R5 oe off after read", lane_oe, 0);
    check(done_cnt - d0 == n, "R4 done pulses on read", done_cnt - d0, n);
  endtask

  initial begin
    #(5.0 * 180000);
    check(1'b0, "watchdog expired", 0, 1);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end

  initial begin
    logic [7:0] d[];
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge sclk);
    // R1 during and after reset
    check(lane_oe == 0 && !irq_denied && !irq_done && !mem_we, "R1 in reset", 0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);
    check(lane_oe == 0 && !irq_denied && !irq_done && !mem_we, "R1 after reset", 0, 0);

    // R2 R3 R4 write burst
    d = new[4]; d = '{8'h11, 8'hA7, 8'h3C, 8'hF0};
    wr_burst(16'h0010, d, 4);
    // R5 read back
    rd_burst(16'h0010, 4);

    // R6 wrap at the top of the address space
    d = new[2]; d = '{8'h9E, 8'h42};
    wr_burst(16'hFFFF, d, 2);
    rd_burst(16'hFFFF, 2);

    // R7 deselect mid-word: only the full word lands
    wq.push_back({16'h0040, 8'h5A});
    send(KEY, 16); send(8'h00, 8); send(16'h0040, 16); send(8'h5A, 8);
    send(4'h7, 4);
    deselect();
    check(wq.size() == 0, "R7 partial word dropped", wq.size(), 0);
    rd_burst(16'h0040, 2);
    // R7 half key then deselect: full key next time works
    send(16'hA5, 8);
    deselect();
    d = new[1]; d = '{8'h3C};
    wr_burst(16'h0080, d, 1);

    // R8 wrong key: lockout of exactly 2^AW clocks
    denied_cnt = 0;
    oe_locked = 0;
    send(16'h1234, 16);
    @(negedge sclk);
    check(irq_denied == 1'b1, "R8 denied raised", irq_denied, 1);
    send(KEY, 16); send(8'h00, 8); send(16'h0020, 16); send(8'hEE, 8);
    deselect();
    send(KEY, 16); send(8'h01, 8);
    deselect();
    while (irq_denied) @(negedge sclk);
    check(denied_cnt == (1 << AW), "R8 lockout length", denied_cnt, 1 << AW);
    check(oe_locked == 0, "R8 lanes idle in lockout", oe_locked, 0);
    check(mem[8'h20] == 8'h00, "R8 no write in lockout", mem[8'h20], 0);

    // R9 access restored after the lockout
    rd_burst(16'h0010, 2);
    d = new[1]; d = '{8'h77};
    wr_burst(16'h0020, d, 1);
    rd_burst(16'h0020, 1);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end
endmodule